// File: doc/BRIEF.md
# Calibrated one-second divider for a real-time clock

This block turns a 32768 Hz oscillator enable into a one-second tick and trims the long-term rate with periodic counter correction. A six-bit minute position counts through a repeating 64-minute correction cycle. A five-bit magnitude N and a sign bit choose how many minutes of that cycle are corrected and in which direction. In each corrected minute, only the first second changes length. It is shortened when the clock must run faster and lengthened when it must run slower. The change is made at the divide-by-256 stage.

The block also drives the pull-down enable of an open-drain status pin. In test mode the pin carries a 512 Hz square wave taken from the uncorrected low stage of the divider. In static mode it follows a level bit. A stop bit holds the whole chain at zero. When the stop bit is released, counting restarts from the beginning of a second, minute and cycle. The width of each stage is a parameter, so a bench can scale the chain down.

Top module: `rtc_cal_divider`

## Requirements
- R1: With no correction, each second lasts 2^(LOW_W+HIGH_W) oscillator enables, which is 32768 by default. `secTick` is high for exactly one clock, in the clock that follows the enable that completes the second.
- R2: When `calSign`=1 and N>0, each affected second is shortened by 2^LOW_W enables (256 by default).
- R3: When `calSign`=0 and N>0, each affected second is lengthened by 2^(LOW_W-1) enables (128 by default).
- R4: The affected second is second 0 of every minute whose position is below 2N. `minPos` counts 0 to 63 and wraps. It advances at the end of every SEC_PER_MIN corrected seconds, in the same clock as the tick.
- R5: When N=0, no second is changed, whatever the value of `calSign`.
- R6: When `ftMode`=1, `pinPullDown` is a square wave whose half-period is 2^(LOW_W-3) enables (512 Hz by default). Calibration does not change it, including during a lengthened second.
- R7: When `ftMode`=0, `pinPullDown` equals the inverse of `outLevel`, so the pin is pulled low only when `outLevel`=0.
- R8: While `stopBit`=1, the divider, the second count and `minPos` are held at zero and no tick is produced. After release, the first second starts from zero in minute 0.
- R9: A clock with `oscEn`=0 does not advance any counter.
- R10: After reset, `secTick`=0 and `minPos`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One-clock enable per oscillator period |
| stopBit | input | 1 | Holds the chain at zero while 1 |
| outLevel | input | 1 | Static pin level used when test mode is off |
| ftMode | input | 1 | 1 selects the 512 Hz test wave on the pin |
| calSign | input | 1 | 1 speeds the clock up, 0 slows it down |
| calMag | input | CAL_W | Correction magnitude N, from 0 to 31 |
| secTick | output | 1 | One-clock pulse at the end of every second |
| minPos | output | CYCLE_W | Position within the 64-minute correction cycle |
| pinPullDown | output | 1 | 1 enables the open-drain pull-down |

## Verification
The embedded assertions check four things on every cycle:
- stop holds the chain at zero;
- idle enables freeze the counters;
- ticks are single-cycle and the low stage stays within its extended bound;
- `minPos` moves only at second ends, and a zero magnitude never produces a correction strobe.

Only the bench scenarios can show the actual second lengths. They cover both correction directions, which seconds and minutes are affected across a full 64-minute cycle, the position wrap, and the stability of the test wave through a lengthened second. They also cover the pin level in static mode and the doubled interval when the enable is gated.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // correction strobes from control to datapath, valid for the current low period
  typedef struct packed {
    logic lengthen;  // stretch this low period by half its length
    logic shorten;   // skip one low period at its wrap
  } corrStrobeT;
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_W       = 5,
  parameter int CYCLE_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopBit,
  input  logic               secEnd,
  input  logic               atSecStart,
  input  logic               calSign,
  input  logic [CAL_W-1:0]   calMag,
  output logic [CYCLE_W-1:0] minPos,
  output corrStrobeT         strobe
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0] secCnt;
  logic             affected;

  always_ff @(posedge clk) begin
    if (!rstN || stopBit) begin
      secCnt <= '0;
      minPos <= '0;
    end else if (secEnd) begin
      if (secCnt == SEC_LAST) begin
        secCnt <= '0;
        minPos <= minPos + 1'b1;
      end else begin
        secCnt <= secCnt + 1'b1;
      end
    end
  end

  always_comb begin
    affected        = (calMag != '0) && (secCnt == '0) &&
                      (int'(minPos) < 2 * int'(calMag));
    strobe.shorten  = affected && atSecStart && calSign;
    strobe.lengthen = affected && atSecStart && !calSign;
  end

  // R5
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calMag == '0) |-> (!strobe.lengthen && !strobe.shorten));
  // R4
  pos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopBit && !secEnd) |=> $stable(minPos));
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       stopBit,
  input  logic       outLevel,
  input  logic       ftMode,
  input  corrStrobeT strobe,
  output logic       secEnd,
  output logic       atSecStart,
  output logic       secTick,
  output logic       pinPullDown
);
  localparam int FT_BIT = LOW_W - 3;
  localparam logic [LOW_W:0] SHORT_TERM = (LOW_W+1)'((1 << LOW_W) - 1);
  localparam logic [LOW_W:0] LONG_TERM  = (LOW_W+1)'((1 << LOW_W) + (1 << (LOW_W-1)) - 1);
  localparam logic [HIGH_W-1:0] HIGH_MAX = '1;
  localparam logic [HIGH_W-1:0] STEP1 = HIGH_W'(1);
  localparam logic [HIGH_W-1:0] STEP2 = HIGH_W'(2);

  logic [LOW_W:0]    lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic [LOW_W:0]    lowTerm;
  logic              lowWrap;

  always_comb begin
    lowTerm    = strobe.lengthen ? LONG_TERM : SHORT_TERM;
    lowWrap    = (lowCnt >= lowTerm);
    atSecStart = (highCnt == '0);
    secEnd     = oscEn && !stopBit && lowWrap && (highCnt == HIGH_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stopBit) begin
      lowCnt  <= '0;
      highCnt <= '0;
      secTick <= 1'b0;
    end else begin
      secTick <= secEnd;
      if (oscEn) begin
        if (lowWrap) begin
          lowCnt  <= '0;
          highCnt <= highCnt + (strobe.shorten ? STEP2 : STEP1);
        end else begin
          lowCnt  <= lowCnt + 1'b1;
        end
      end
    end
  end

  // test wave is tapped from the low stage, whose bit toggles at a fixed rate
  assign pinPullDown = ftMode ? lowCnt[FT_BIT] : !outLevel;

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> (lowCnt == '0 && highCnt == '0 && !secTick));
  // R3
  low_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LONG_TERM);
  // R1
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !stopBit) |=> ($stable(lowCnt) && $stable(highCnt)));
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
  import rtc_cal_pkg::*;
#(
  parameter int LOW_W       = 8,
  parameter int HIGH_W      = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_W       = 5,
  parameter int CYCLE_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oscEn,
  input  logic               stopBit,
  input  logic               outLevel,
  input  logic               ftMode,
  input  logic               calSign,
  input  logic [CAL_W-1:0]   calMag,
  output logic               secTick,
  output logic [CYCLE_W-1:0] minPos,
  output logic               pinPullDown
);
  corrStrobeT strobe;
  logic       secEnd;
  logic       atSecStart;

  rtc_cal_ctrl #(
    .SEC_PER_MIN(SEC_PER_MIN), .CAL_W(CAL_W), .CYCLE_W(CYCLE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .stopBit(stopBit), .secEnd(secEnd),
    .atSecStart(atSecStart), .calSign(calSign), .calMag(calMag),
    .minPos(minPos), .strobe(strobe)
  );

  rtc_cal_datapath #(
    .LOW_W(LOW_W), .HIGH_W(HIGH_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopBit(stopBit),
    .outLevel(outLevel), .ftMode(ftMode), .strobe(strobe),
    .secEnd(secEnd), .atSecStart(atSecStart), .secTick(secTick),
    .pinPullDown(pinPullDown)
  );
endmodule

// File: tb/rtc_cal_divider_tb_top.sv
module rtc_cal_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4, HW = 3, SPM = 4;
  localparam int NOMINAL = 1 << (LW + HW);   // 128
  localparam int FAST    = NOMINAL - (1 << LW);      // 112
  localparam int SLOW    = NOMINAL + (1 << (LW - 1)); // 136

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b1;
  logic stopBit = 1'b0, outLevel = 1'b1, ftMode = 1'b0, calSign = 1'b0;
  logic [4:0] calMag = '0;
  logic secTick, pinPullDown;
  logic [5:0] minPos;
  int total = 0, bad = 0, cyc = 0, enDiv = 1, phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_cal_divider #(.LOW_W(LW), .HIGH_W(HW), .SEC_PER_MIN(SPM)) dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopBit(stopBit),
    .outLevel(outLevel), .ftMode(ftMode), .calSign(calSign), .calMag(calMag),
    .secTick(secTick), .minPos(minPos), .pinPullDown(pinPullDown)
  );

  // enable pattern: one enable every enDiv clocks, changed at the falling edge
  always @(negedge clk) begin
    phase = (phase + 1 >= enDiv) ? 0 : phase + 1;
    oscEn = (phase == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nextGap(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!secTick);
  endtask

  task automatic restart(input logic sgn, input int mag);
    stopBit = 1'b1; calSign = sgn; calMag = 5'(mag);
    repeat (3) @(negedge clk);
    check("R8 stopped position", int'(minPos), 0);
    check("R8 stopped tick", int'(secTick), 0);
    stopBit = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset tick", int'(secTick), 0);
    check("R10 reset position", int'(minPos), 0);
    check("R7 pin released for level 1", int'(pinPullDown), 0);
  endtask

  task automatic t_zero();
    int g;
    restart(1'b1, 0);
    for (int i = 0; i < 6; i++) begin nextGap(g); check("R5 zero mag sign1", g, NOMINAL); end
    restart(1'b0, 0);
    for (int i = 0; i < 5; i++) begin nextGap(g); check("R1 R5 zero mag sign0", g, NOMINAL); end
  endtask

  task automatic t_one(input logic sgn);
    int g, exp;
    restart(sgn, 1);
    for (int i = 0; i < 3 * SPM; i++) begin
      nextGap(g);
      exp = (i % SPM == 0 && i / SPM < 2) ? (sgn ? FAST : SLOW) : NOMINAL;
      if (sgn) check("R2 positive N=1", g, exp);
      else     check("R3 negative N=1", g, exp);
    end
  endtask

  task automatic t_cycle();
    int g, exp, errs = 0, posErrs = 0;
    restart(1'b1, 31);
    for (int i = 0; i < 64 * SPM + SPM; i++) begin
      nextGap(g);
      exp = (i % SPM == 0 && (i / SPM) % 64 < 62) ? FAST : NOMINAL;
      if (g != exp) begin
        errs++;
        $display("FAIL R4 second %0d: actual=%0d expected=%0d", i, g, exp);
      end
      if (int'(minPos) != ((i + 1) / SPM) % 64) posErrs++;
    end
    check("R4 full-cycle second lengths", errs, 0);
    check("R4 position tracking and wrap", posErrs, 0);
  endtask

  task automatic t_ftwave();
    int runLen = 1, badRuns = 0;
    logic prev;
    ftMode = 1'b1;
    restart(1'b0, 31);
    prev = pinPullDown;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pinPullDown == prev) runLen++;
      else begin
        if (runLen != (1 << (LW - 3))) badRuns++;
        runLen = 1; prev = pinPullDown;
      end
    end
    check("R6 test wave half-period constant", badRuns, 0);
    ftMode = 1'b0;
  endtask

  task automatic t_level();
    outLevel = 1'b0; @(negedge clk);
    check("R7 level 0 pulls low", int'(pinPullDown), 1);
    outLevel = 1'b1; @(negedge clk);
    check("R7 level 1 releases", int'(pinPullDown), 0);
  endtask

  task automatic t_stop();
    int ticks = 0;
    stopBit = 1'b1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (secTick) ticks++; end
    check("R8 no ticks while stopped", ticks, 0);
    check("R8 position held", int'(minPos), 0);
    stopBit = 1'b0;
  endtask

  task automatic t_gated();
    int g;
    enDiv = 2;
    restart(1'b0, 0);
    nextGap(g);
    nextGap(g); check("R9 gated enable doubles second", g, 2 * NOMINAL);
    nextGap(g); check("R9 gated enable second 3", g, 2 * NOMINAL);
    enDiv = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_zero();
    t_one(1'b1);
    t_one(1'b0);
    t_cycle();
    t_ftwave();
    t_level();
    t_stop();
    t_gated();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule